// File: doc/BRIEF.md
# Keyboard and Display Register Port

This block is a bus slave that gives a processor a byte-wide keyboard input channel and a byte-wide display output channel through four 32-bit registers at fixed high addresses. Each channel has a control word and a data word. Software may poll the ready flag in bit 0 of a control word with a 0x1 mask, or it may set the interrupt-enable bit and wait for the shared interrupt line.

On the keyboard side, an incoming byte is taken into a holding register and the ready flag is set. A load from the keyboard data word returns the byte and clears the flag, so the next byte can come in. On the display side, the ready flag shows that the display can take a byte. A store to the display data word presents the byte on a valid/ready output and drops the flag until the display takes the byte. Key scanning and display drive lie outside the block. They appear as simple valid/ready ports.

The base address defaults to 0xffff0000. The keyboard control word is at offset 0x0, the keyboard data word at 0x4, the display control word at 0x8 and the display data word at 0xc.

Top module: `kdio_slave`

## Requirements
- R1: Only a word-aligned access (address bits 1:0 zero) to base+0x0, base+0x4, base+0x8 or base+0xc is decoded. Any other read returns 0, a cycle with no read returns 0, and any other write changes no state.
- R2: A control word reads as the ready flag in bit 0 and the interrupt enable in bit 1, with bits 31:2 at zero. A data word reads as its byte in bits 7:0, with bits 31:8 at zero.
- R3: key_ready is high while the keyboard holding register is empty. A cycle with key_valid and key_ready both high stores key_byte and sets the keyboard ready flag from the next cycle on.
- R4: A read of the keyboard data word returns the stored byte. If the flag was set, the read clears it from the next cycle on.
- R5: While the keyboard flag is set, key_ready is low and further key bytes are ignored. The stored byte does not change.
- R6: The display control word's ready flag is 1 while the display channel is idle.
- R7: A write to the display data word while the display is ready stores bits 7:0. From the next cycle on, the ready flag is 0, disp_valid is 1 and disp_byte carries the byte.
- R8: A cycle with disp_valid and disp_ready both high completes the transfer. From the next cycle on, disp_valid is 0 and the display ready flag is 1.
- R9: A write to the display data word while a byte is pending is ignored. disp_byte and the data word keep their old value.
- R10: In a control word only bit 1 (interrupt enable) is writable. The ready flags and a write to the keyboard data word have no effect.
- R11: irq equals (keyboard flag AND keyboard enable) OR (display ready AND display enable).
- R12: After reset both enables are 0, the keyboard is empty, the display is ready, both data words read 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Load strobe |
| bus_wr | input | 1 | Store strobe |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, same cycle |
| key_valid | input | 1 | Keyboard offers a byte |
| key_byte | input | 8 | Keyboard byte |
| key_ready | output | 1 | Holding register can accept a byte |
| disp_valid | output | 1 | A byte is pending for the display |
| disp_byte | output | 8 | Pending display byte |
| disp_ready | input | 1 | Display takes the pending byte |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the handshake rules at the two device ports. These are the fill and hold of the keyboard holding register, the clearing by a data read, the presentation, hold and completion of a display byte, and a zero read bus when no load is made. Only the bench scenarios show the address decode against unmapped and unaligned addresses, the bit layout of the control words, the interrupt combining and the write masking of the control words. The bench sweeps all 256 byte values through both channels and every enable and flag combination.

// File: rtl/kdio_pkg.sv
package kdio_pkg;
    localparam int WORD_W  = 32;
    localparam int CHAR_W  = 8;
    localparam int NREGS   = 4;
    localparam int IDX_W   = $clog2(NREGS);
    localparam int RDY_BIT = 0;
    localparam int IEN_BIT = 1;

    typedef enum logic [IDX_W-1:0] {
        KD_KEY_CTRL = 2'd0,
        KD_KEY_DATA = 2'd1,
        KD_DSP_CTRL = 2'd2,
        KD_DSP_DATA = 2'd3
    } kd_reg_e;

    typedef struct packed {
        logic ready;
        logic ien;
    } kd_ctrl_t;

    typedef struct packed {
        logic [NREGS-1:0] rd_sel;
        logic [NREGS-1:0] wr_sel;
    } kd_strobe_t;

    function automatic logic [WORD_W-1:0] pack_ctrl(kd_ctrl_t c);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[RDY_BIT] = c.ready;
        w[IEN_BIT] = c.ien;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_char(logic [CHAR_W-1:0] b);
        return {{(WORD_W-CHAR_W){1'b0}}, b};
    endfunction
endpackage

// File: rtl/kdio_decode.sv
module kdio_decode
    import kdio_pkg::*;
#(
    parameter logic [WORD_W-1:0] BASE_ADDR = 32'hffff_0000
) (
    input  logic [WORD_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output kd_strobe_t        strb
);
    localparam int LOW_W = IDX_W + 2;

    logic             base_hit;
    logic [IDX_W-1:0] idx;
    logic [NREGS-1:0] rd_v;
    logic [NREGS-1:0] wr_v;

    assign base_hit = (addr[WORD_W-1:LOW_W] == BASE_ADDR[WORD_W-1:LOW_W])
                   && (addr[1:0] == 2'b00);
    assign idx = addr[LOW_W-1:2];

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_sel
            assign rd_v[g] = rd && base_hit && (idx == IDX_W'(g));
            assign wr_v[g] = wr && base_hit && (idx == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        strb.rd_sel = rd_v;
        strb.wr_sel = wr_v;
    end
endmodule

// File: rtl/kdio_kbd_port.sv
module kdio_kbd_port
    import kdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_byte,
    output logic              key_ready,
    input  logic              ien_wr,
    input  logic              ien_wdata,
    input  logic              data_rd,
    output kd_ctrl_t          ctrl,
    output logic [CHAR_W-1:0] char_out
);
    logic              full_q;
    logic              ien_q;
    logic [CHAR_W-1:0] char_q;

    assign key_ready  = !full_q;
    assign ctrl.ready = full_q;
    assign ctrl.ien   = ien_q;
    assign char_out   = char_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            ien_q  <= 1'b0;
            char_q <= '0;
        end else begin
            if (ien_wr) begin
                ien_q <= ien_wdata;
            end
            if (key_valid && !full_q) begin
                char_q <= key_byte;
                full_q <= 1'b1;
            end else if (data_rd) begin
                full_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/kdio_disp_port.sv
module kdio_disp_port
    import kdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] data_wbyte,
    input  logic              ien_wr,
    input  logic              ien_wdata,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_byte,
    input  logic              disp_ready,
    output kd_ctrl_t          ctrl
);
    logic              rdy_q;
    logic              ien_q;
    logic [CHAR_W-1:0] char_q;

    assign disp_valid = !rdy_q;
    assign disp_byte  = char_q;
    assign ctrl.ready = rdy_q;
    assign ctrl.ien   = ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q  <= 1'b1;
            ien_q  <= 1'b0;
            char_q <= '0;
        end else begin
            if (ien_wr) begin
                ien_q <= ien_wdata;
            end
            if (data_wr && rdy_q) begin
                char_q <= data_wbyte;
                rdy_q  <= 1'b0;
            end else if (!rdy_q && disp_ready) begin
                rdy_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/kdio_slave.sv
module kdio_slave
    import kdio_pkg::*;
#(
    parameter logic [WORD_W-1:0] BASE_ADDR = 32'hffff_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_byte,
    output logic              key_ready,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_byte,
    input  logic              disp_ready,
    output logic              irq
);
    kd_strobe_t        strb;
    kd_ctrl_t          kctrl;
    kd_ctrl_t          dctrl;
    logic [CHAR_W-1:0] kchar;
    logic              unused_wbits;

    assign unused_wbits = ^{bus_wdata[WORD_W-1:CHAR_W], bus_wdata[0]};

    kdio_decode #(.BASE_ADDR(BASE_ADDR)) dec_i (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .strb (strb)
    );

    kdio_kbd_port kbd_i (
        .clk       (clk),
        .rst       (rst),
        .key_valid (key_valid),
        .key_byte  (key_byte),
        .key_ready (key_ready),
        .ien_wr    (strb.wr_sel[KD_KEY_CTRL]),
        .ien_wdata (bus_wdata[IEN_BIT]),
        .data_rd   (strb.rd_sel[KD_KEY_DATA]),
        .ctrl      (kctrl),
        .char_out  (kchar)
    );

    kdio_disp_port dsp_i (
        .clk        (clk),
        .rst        (rst),
        .data_wr    (strb.wr_sel[KD_DSP_DATA]),
        .data_wbyte (bus_wdata[CHAR_W-1:0]),
        .ien_wr     (strb.wr_sel[KD_DSP_CTRL]),
        .ien_wdata  (bus_wdata[IEN_BIT]),
        .disp_valid (disp_valid),
        .disp_byte  (disp_byte),
        .disp_ready (disp_ready),
        .ctrl       (dctrl)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            strb.rd_sel[KD_KEY_CTRL]: bus_rdata = pack_ctrl(kctrl);
            strb.rd_sel[KD_KEY_DATA]: bus_rdata = pack_char(kchar);
            strb.rd_sel[KD_DSP_CTRL]: bus_rdata = pack_ctrl(dctrl);
            strb.rd_sel[KD_DSP_DATA]: bus_rdata = pack_char(disp_byte);
            default:                  bus_rdata = '0;
        endcase
    end

    assign irq = (kctrl.ready && kctrl.ien) || (dctrl.ready && dctrl.ien);
endmodule

// File: rtl/kdio_chk.sv
module kdio_chk
    import kdio_pkg::*;
#(
    parameter logic [WORD_W-1:0] BASE_ADDR = 32'hffff_0000
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              key_valid,
    input logic              key_ready,
    input logic              disp_valid,
    input logic [CHAR_W-1:0] disp_byte,
    input logic              disp_ready
);
    logic kdata_rd;
    logic ddata_wr;
    assign kdata_rd = bus_rd && (bus_addr == BASE_ADDR + 32'h4);
    assign ddata_wr = bus_wr && (bus_addr == BASE_ADDR + 32'hc);

    // R1
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0);

    // R3
    key_fill_chk: assert property (@(posedge clk) disable iff (rst)
        key_valid && key_ready |=> !key_ready);

    // R5
    key_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !key_ready && !kdata_rd |=> !key_ready);

    // R4
    key_drain_chk: assert property (@(posedge clk) disable iff (rst)
        kdata_rd && !key_valid |=> key_ready);

    // R7
    disp_load_chk: assert property (@(posedge clk) disable iff (rst)
        ddata_wr && !disp_valid |=> disp_valid && disp_byte == $past(bus_wdata[CHAR_W-1:0]));

    // R8
    disp_done_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid && disp_ready |=> !disp_valid);

    // R9
    disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_byte));
endmodule

bind kdio_slave kdio_chk #(.BASE_ADDR(BASE_ADDR)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .key_valid  (key_valid),
    .key_ready  (key_ready),
    .disp_valid (disp_valid),
    .disp_byte  (disp_byte),
    .disp_ready (disp_ready)
);

// File: tb/kdio_slave_tb_top.sv
module kdio_slave_tb_top;
    localparam logic [31:0] BASE = 32'hffff_0000;
    localparam logic [31:0] A_KC = BASE + 32'h0;
    localparam logic [31:0] A_KD = BASE + 32'h4;
    localparam logic [31:0] A_DC = BASE + 32'h8;
    localparam logic [31:0] A_DD = BASE + 32'hc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        key_valid = 1'b0;
    logic [7:0]  key_byte = '0;
    logic        key_ready;
    logic        disp_valid;
    logic [7:0]  disp_byte;
    logic        disp_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    kdio_slave #(.BASE_ADDR(BASE)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_valid(key_valid),
        .key_byte(key_byte), .key_ready(key_ready), .disp_valid(disp_valid),
        .disp_byte(disp_byte), .disp_ready(disp_ready), .irq(irq)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic send_key(input logic [7:0] b);
        @(negedge clk);
        key_valid = 1'b1; key_byte = b;
        @(posedge clk); #1 key_valid = 1'b0;
    endtask

    task automatic consume();
        @(negedge clk);
        disp_ready = 1'b1;
        @(posedge clk); #1 disp_ready = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R12 reset state
        rd(A_KC, v); check(v, 32'h0, "R12 key ctrl");
        rd(A_KD, v); check(v, 32'h0, "R12 key data");
        rd(A_DC, v); check(v, 32'h1, "R12 disp ctrl");
        rd(A_DD, v); check(v, 32'h0, "R12 disp data");
        check({31'b0, irq}, 32'h0, "R12 irq");
        check({31'b0, key_ready}, 32'h1, "R12 key_ready");
        check({31'b0, disp_valid}, 32'h0, "R12 disp_valid");

        // R3 R4 R2 keyboard sweep over all bytes
        for (int b = 0; b < 256; b++) begin
            send_key(8'(b));
            check({31'b0, key_ready}, 32'h0, "R3 key_ready low after fill");
            rd(A_KC, v); check(v, 32'h1, "R2 key ctrl full");
            rd(A_KD, v); check(v, 32'(b), "R4 key data");
            rd(A_KC, v); check(v, 32'h0, "R4 flag cleared");
        end

        // R5 second byte ignored while full
        send_key(8'h5a);
        send_key(8'hc3);
        rd(A_KD, v); check(v, 32'h5a, "R5 held byte");
        check({31'b0, key_ready}, 32'h1, "R4 ready after read");

        // R6 R7 R8 display sweep over all bytes
        for (int b = 0; b < 256; b++) begin
            rd(A_DC, v); check(v, 32'h1, "R6 disp ready idle");
            wr(A_DD, 32'hffff_ff00 | 32'(b));
            check({31'b0, disp_valid}, 32'h1, "R7 disp_valid");
            check({24'b0, disp_byte}, 32'(b), "R7 disp_byte");
            rd(A_DC, v); check(v, 32'h0, "R7 disp ready low");
            rd(A_DD, v); check(v, 32'(b), "R2 disp data");
            consume();
            check({31'b0, disp_valid}, 32'h0, "R8 disp_valid dropped");
        end

        // R9 write while busy ignored
        wr(A_DD, 32'h11);
        repeat (2) @(posedge clk);
        wr(A_DD, 32'h22);
        check({24'b0, disp_byte}, 32'h11, "R9 disp_byte kept");
        rd(A_DD, v); check(v, 32'h11, "R9 disp data kept");
        consume();

        // R10 control write mask
        wr(A_KC, 32'hffff_ffff);
        rd(A_KC, v); check(v, 32'h2, "R10 key ctrl only enable");
        wr(A_DC, 32'hffff_fffe);
        rd(A_DC, v); check(v, 32'h3, "R10 disp ctrl enable set");
        wr(A_DC, 32'h0);
        rd(A_DC, v); check(v, 32'h1, "R10 disp ready not writable");
        send_key(8'h77);
        wr(A_KD, 32'h0);
        rd(A_KC, v); check(v, 32'h3, "R10 key data write ignored flag");
        rd(A_KD, v); check(v, 32'h77, "R10 key data write ignored byte");
        wr(A_KC, 32'h0);

        // R1 decode: unmapped and unaligned addresses
        for (int k = 0; k < 64; k++) begin
            logic [31:0] a;
            a = BASE + 32'(k);
            if (k >= 16 || (k % 4) != 0) begin
                rd(a, v); check(v, 32'h0, "R1 unmapped read");
                wr(a, 32'hffff_ffff);
            end
        end
        rd(32'h7fff_0004, v); check(v, 32'h0, "R1 wrong upper bits");
        wr(32'h0fff_000c, 32'h99);
        check({31'b0, disp_valid}, 32'h0, "R1 foreign write no display");
        rd(A_KC, v); check(v, 32'h0, "R1 key ctrl untouched");
        rd(A_DC, v); check(v, 32'h1, "R1 disp ctrl untouched");

        // R11 interrupt combinations
        for (int c = 0; c < 16; c++) begin
            logic kie, die, kf, dr, exp_irq;
            kie = c[0]; die = c[1]; kf = c[2]; dr = c[3];
            wr(A_KC, {30'b0, kie, 1'b0});
            wr(A_DC, {30'b0, die, 1'b0});
            if (kf) send_key(8'(c));
            if (!dr) wr(A_DD, 32'(c));
            #2;
            exp_irq = (kf & kie) | (dr & die);
            check({31'b0, irq}, {31'b0, exp_irq}, "R11 irq");
            if (kf) rd(A_KD, v);
            if (!dr) consume();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule